// File: doc/BRIEF.md
# Cycle-Timed Memory Reference Controller

This block runs the memory side of a microcoded processor. A reference opens when the processor presents an address. From then on, a small counter numbers the clock periods of that reference. Reads and writes of the synchronous RAM behind the block happen only in fixed, numbered periods. The RAM has a single port, so each cycle carries at most one read or one write.

A read fetches two words: the one at the given address and its partner, which differs only in the lowest address bit. Each lands in its own holding register. A write can cover one word or a pair.

The processor asks the block before each memory action. One ready line exists for each kind of action: opening a reference, taking read data, and supplying store data. The block also raises a hold line. While hold is high, the processor repeats its whole microinstruction in the next cycle.

Some requests come at a period that can never be right, such as a read before the data could exist or a store after the write window has closed. These requests raise a sticky error flag and leave memory untouched.

Period numbering works as follows. The clock period that follows the edge accepting an address is period 1. Each later period is one higher. The count stops at its largest value instead of wrapping.

Top module: `memref_ctrl`

## Requirements
- R1: After reset, `lda_rdy`, `rd_rdy` and `st_rdy` are all high, while `cpu_hold` and `timing_err` are low. `rd_data` shows the first-word register, which reset clears to zero.
- R2: An accepted address request opens a reference. `lda_rdy` is low during periods 1 to 4 and high again from period 5.
- R3: `st_rdy` is low in periods 1 and 2 and high from period 3. `rd_rdy` is low in periods 1 to 4 and high from period 5. When `lda_rdy` is high, the other two ready lines are high as well.
- R4: `cpu_hold` is high in any cycle where a request is present while its ready line is low. In that cycle, none of the requests changes the memory or the reference.
- R5: A read in period 5 returns the word at the reference address. A read in period 6 returns the word at the address with bit 0 inverted.
- R6: A read in period 7 or later, or before any reference since reset, returns the first-word register. This holds because the counter stays at its maximum.
- R7: Stores in periods 3 and 4 write a pair of words. The period-3 store writes the reference address and the period-4 store writes the address with bit 0 inverted.
- R8: A store in period 4 without a store in period 3 writes the reference address itself. The partner word is left unchanged.
- R9: A read request in period 1 or 2 sets `timing_err`.
- R10: A store request in period 1, 2 or 5 sets `timing_err` and writes nothing.
- R11: An address request while a reference is open sets `timing_err`. The open reference keeps its address and its period count.
- R12: `timing_err` stays high until reset.
- R13: A store in period 6 or later, or with no reference since reset, writes nothing. It also raises neither `cpu_hold` nor `timing_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lda_req | input | 1 | Request to open a reference at `lda_addr` |
| lda_addr | input | ADDR_W | Reference address |
| rd_req | input | 1 | Request to take read data |
| st_req | input | 1 | Request to store `st_data` |
| st_data | input | DATA_W | Store data |
| lda_rdy | output | 1 | Address request may proceed |
| rd_rdy | output | 1 | Read request may proceed |
| st_rdy | output | 1 | Store request may proceed |
| cpu_hold | output | 1 | Microinstruction must be repeated next cycle |
| rd_data | output | DATA_W | Read data for the current period |
| timing_err | output | 1 | Sticky illegal-timing flag |

## Verification
Pairs are written at an even address and read back from both the even address and the odd address. Because the odd read returns the pair in reverse order, an inverted-bit partner can be told apart from an incremented one. A single period-4 store that follows an earlier pair write shows whether the pair flag survives from one reference to the next.

Reads issued from period 3 through period 7 separate a stall from a first word, a second word and the saturated count. Illegal requests are each followed by a legal read-back, which shows that memory and the period count were not disturbed. Late stores, in period 5 and in period 6, show the difference between a flagged store and a silently ignored one.

// File: rtl/memref_pkg.sv
package memref_pkg;

    // Period numbers of a reference; period 1 follows the accepting edge.
    localparam int unsigned PER_FIRST    = 1;
    localparam int unsigned PER_EARLY    = 2;
    localparam int unsigned PER_SLOT_A   = 3;
    localparam int unsigned PER_SLOT_B   = 4;
    localparam int unsigned PER_CLOSE    = 5;
    localparam int unsigned PER_PAIR_OUT = 6;

    typedef struct packed {
        logic lda_ok;
        logic rd_ok;
        logic st_ok;
    } ready_t;

endpackage

// File: rtl/memref_timer.sv
module memref_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             set_pair,
    output logic [CNT_W-1:0] per,
    output logic             open,
    output logic             pair
);
    import memref_pkg::*;

    localparam logic [CNT_W-1:0] PER_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PER_ONE  = CNT_W'(PER_FIRST);
    localparam logic [CNT_W-1:0] PER_LAST = CNT_W'(PER_SLOT_B);

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic             open;
        logic             pair;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.per != PER_MAX) begin
            st_d.per = st_q.per + 1'b1;
        end
        if (st_q.open && st_q.per == PER_LAST) begin
            st_d.open = 1'b0;
            st_d.pair = 1'b0;
        end
        if (set_pair) begin
            st_d.pair = 1'b1;
        end
        if (start) begin
            st_d.per  = PER_ONE;
            st_d.open = 1'b1;
            st_d.pair = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.per  <= PER_MAX;
            st_q.open <= 1'b0;
            st_q.pair <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign per  = st_q.per;
    assign open = st_q.open;
    assign pair = st_q.pair;

endmodule

// File: rtl/memref_gate.sv
module memref_gate #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             lda_req,
    input  logic             rd_req,
    input  logic             st_req,
    input  logic [CNT_W-1:0] per,
    input  logic             open,
    output memref_pkg::ready_t rdy,
    output logic             hold,
    output logic             err_evt,
    output logic             lda_go,
    output logic             st_go
);
    import memref_pkg::*;

    localparam logic [CNT_W-1:0] P1 = CNT_W'(PER_FIRST);
    localparam logic [CNT_W-1:0] P2 = CNT_W'(PER_EARLY);
    localparam logic [CNT_W-1:0] P4 = CNT_W'(PER_SLOT_B);
    localparam logic [CNT_W-1:0] P5 = CNT_W'(PER_CLOSE);

    logic early;
    logic bad_lda;
    logic bad_rd;
    logic bad_st;
    logic go;

    always_comb begin
        early      = open && (per == P1 || per == P2);
        rdy.lda_ok = !open;
        rdy.rd_ok  = !(open && per <= P4);
        rdy.st_ok  = !early;

        hold = (lda_req && !rdy.lda_ok)
             || (rd_req && !rdy.rd_ok)
             || (st_req && !rdy.st_ok);

        bad_lda = lda_req && open;
        bad_rd  = rd_req && early;
        bad_st  = st_req && (early || per == P5);
        err_evt = bad_lda || bad_rd || bad_st;

        go     = !hold && !err_evt;
        lda_go = lda_req && go;
        st_go  = st_req && go && open;
    end

endmodule

// File: rtl/memref_ram.sv
module memref_ram #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata_q <= mem[addr];
            end
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/memref_ctrl.sv
module memref_ctrl #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lda_req,
    input  logic [ADDR_W-1:0] lda_addr,
    input  logic              rd_req,
    input  logic              st_req,
    input  logic [DATA_W-1:0] st_data,
    output logic              lda_rdy,
    output logic              rd_rdy,
    output logic              st_rdy,
    output logic              cpu_hold,
    output logic [DATA_W-1:0] rd_data,
    output logic              timing_err
);
    import memref_pkg::*;

    localparam logic [CNT_W-1:0] PA = CNT_W'(PER_SLOT_A);
    localparam logic [CNT_W-1:0] PB = CNT_W'(PER_SLOT_B);
    localparam logic [CNT_W-1:0] PC = CNT_W'(PER_CLOSE);
    localparam logic [CNT_W-1:0] P6 = CNT_W'(PER_PAIR_OUT);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] word0;
        logic [DATA_W-1:0] word1;
        logic              fresh;
        logic              err;
    } dstate_t;

    dstate_t ds_d, ds_q;

    logic [CNT_W-1:0]  per_w;
    logic              open_w;
    logic              pair_w;
    ready_t            rdy_w;
    logic              hold_w;
    logic              err_evt_w;
    logic              lda_go_w;
    logic              st_go_w;
    logic              st_slot_a;
    logic              st_slot_b;
    logic              ram_en_w;
    logic              ram_we_w;
    logic [ADDR_W-1:0] ram_addr_w;
    logic [ADDR_W-1:0] partner_w;
    logic [DATA_W-1:0] ram_q_w;

    memref_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (lda_go_w),
        .set_pair (st_slot_a),
        .per      (per_w),
        .open     (open_w),
        .pair     (pair_w)
    );

    memref_gate #(.CNT_W(CNT_W)) gate_i (
        .lda_req (lda_req),
        .rd_req  (rd_req),
        .st_req  (st_req),
        .per     (per_w),
        .open    (open_w),
        .rdy     (rdy_w),
        .hold    (hold_w),
        .err_evt (err_evt_w),
        .lda_go  (lda_go_w),
        .st_go   (st_go_w)
    );

    memref_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
        .clk   (clk),
        .en    (ram_en_w),
        .we    (ram_we_w),
        .addr  (ram_addr_w),
        .wdata (st_data),
        .rdata (ram_q_w)
    );

    // RAM slot schedule: period A serves the base word, period B its partner.
    always_comb begin
        partner_w  = {ds_q.addr[ADDR_W-1:1], ~ds_q.addr[0]};
        st_slot_a  = st_go_w && per_w == PA;
        st_slot_b  = st_go_w && per_w == PB;
        ram_en_w   = 1'b0;
        ram_we_w   = 1'b0;
        ram_addr_w = ds_q.addr;
        if (open_w && per_w == PA) begin
            ram_en_w   = 1'b1;
            ram_we_w   = st_slot_a;
            ram_addr_w = ds_q.addr;
        end else if (open_w && per_w == PB) begin
            ram_en_w   = 1'b1;
            ram_we_w   = st_slot_b;
            ram_addr_w = (st_slot_b && !pair_w) ? ds_q.addr : partner_w;
        end
    end

    always_comb begin
        ds_d       = ds_q;
        ds_d.err   = ds_q.err | err_evt_w;
        ds_d.fresh = ram_en_w && !ram_we_w;
        if (lda_go_w) begin
            ds_d.addr = lda_addr;
        end
        if (per_w == PB && ds_q.fresh) begin
            ds_d.word0 = ram_q_w;
        end
        if (per_w == PC && ds_q.fresh) begin
            ds_d.word1 = ram_q_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_q.addr  <= '0;
            ds_q.word0 <= '0;
            ds_q.word1 <= '0;
            ds_q.fresh <= 1'b0;
            ds_q.err   <= 1'b0;
        end else begin
            ds_q <= ds_d;
        end
    end

    assign lda_rdy    = rdy_w.lda_ok;
    assign rd_rdy     = rdy_w.rd_ok;
    assign st_rdy     = rdy_w.st_ok;
    assign cpu_hold   = hold_w;
    assign timing_err = ds_q.err;
    assign rd_data    = (per_w == P6) ? ds_q.word1 : ds_q.word0;

endmodule

// File: rtl/memref_ctrl_chk.sv
module memref_ctrl_chk #(
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lda_req,
    input logic             rd_req,
    input logic             st_req,
    input logic             lda_rdy,
    input logic             rd_rdy,
    input logic             st_rdy,
    input logic             cpu_hold,
    input logic             timing_err,
    input logic [CNT_W-1:0] per,
    input logic             open,
    input logic             ram_we
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (lda_req && !cpu_hold) |=> (!lda_rdy && !rd_rdy && !st_rdy)); // R2

    AST_READY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        lda_rdy |-> (rd_rdy && st_rdy)); // R3

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (st_req && st_rdy && !cpu_hold)); // R4

    AST_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && open && (per == CNT_W'(1) || per == CNT_W'(2))) |=> timing_err); // R9

    AST_LATE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && per == CNT_W'(5)) |=> (timing_err && !ram_we)); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |=> timing_err); // R12
endmodule

bind memref_ctrl memref_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lda_req    (lda_req),
    .rd_req     (rd_req),
    .st_req     (st_req),
    .lda_rdy    (lda_rdy),
    .rd_rdy     (rd_rdy),
    .st_rdy     (st_rdy),
    .cpu_hold   (cpu_hold),
    .timing_err (timing_err),
    .per        (per_w),
    .open       (open_w),
    .ram_we     (ram_we_w)
);

// File: tb/memref_ctrl_tb.sv
`timescale 1ns/1ps
module memref_ctrl_tb_top;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lda_req = 1'b0;
    logic [AW-1:0] lda_addr = '0;
    logic          rd_req = 1'b0;
    logic          st_req = 1'b0;
    logic [DW-1:0] st_data = '0;
    logic          lda_rdy, rd_rdy, st_rdy, cpu_hold, timing_err;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;

    memref_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .lda_req(lda_req), .lda_addr(lda_addr),
        .rd_req(rd_req), .st_req(st_req), .st_data(st_data),
        .lda_rdy(lda_rdy), .rd_rdy(rd_rdy), .st_rdy(st_rdy),
        .cpu_hold(cpu_hold), .rd_data(rd_data), .timing_err(timing_err)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one period's requests; returns 1 ns after the falling edge
    task automatic drive(input logic l, input logic [AW-1:0] a, input logic r,
                         input logic s, input logic [DW-1:0] d);
        @(negedge clk);
        lda_req = l; lda_addr = a; rd_req = r; st_req = s; st_data = d;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic rd_expect(input logic [DW-1:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        drive(1'b0, '0, 1'b1, 1'b0, '0);
    endtask

    task automatic do_reset();
        idle(1);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    // pair write: address, periods 1..2 idle, stores in 3 and 4, period 5 idle
    task automatic write_pair(input logic [AW-1:0] a, input logic [DW-1:0] w0, input logic [DW-1:0] w1);
        drive(1'b1, a, 1'b0, 1'b0, '0);
        idle(2);
        drive(1'b0, '0, 1'b0, 1'b1, w0);
        drive(1'b0, '0, 1'b0, 1'b1, w1);
        idle(1);
    endtask

    // pair read: address, periods 1..4 idle, reads in 5 and 6
    task automatic read_pair(input logic [AW-1:0] a, input logic [DW-1:0] w0,
                             input logic [DW-1:0] w1, input string tag);
        drive(1'b1, a, 1'b0, 1'b0, '0);
        idle(4);
        rd_expect(w0, tag);
        rd_expect(w1, tag);
        idle(1);
    endtask

    // scoreboard monitor: pops an expectation for every read that proceeds
    always @(negedge clk) begin
        #2;
        if (rst_n && rd_req && !cpu_hold) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL unexpected read actual=%0h expected=none", rd_data);
            end else begin
                chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk({lda_rdy, rd_rdy, st_rdy, cpu_hold, timing_err}, 5'b11100, "R1 ready/hold/err");
        chk(rd_data, 0, "R1 rd_data");
        rd_expect(16'h0000, "R6 read before any reference");

        // R2 / R3 ready timing across one reference
        drive(1'b1, 8'h10, 1'b0, 1'b0, '0);
        idle(1);
        chk({lda_rdy, rd_rdy, st_rdy}, 3'b000, "R2 R3 period 1");
        idle(1);
        chk({lda_rdy, rd_rdy, st_rdy}, 3'b000, "R3 period 2");
        drive(1'b0, '0, 1'b0, 1'b1, 16'h1111);
        chk({lda_rdy, rd_rdy, st_rdy, cpu_hold}, 4'b0010, "R3 period 3");
        drive(1'b0, '0, 1'b0, 1'b1, 16'h2222);
        chk({lda_rdy, rd_rdy, st_rdy}, 3'b001, "R2 R3 period 4");
        idle(1);
        chk({lda_rdy, rd_rdy, st_rdy}, 3'b111, "R2 period 5");

        // R4 R5 stall then pair read at even address
        drive(1'b1, 8'h10, 1'b0, 1'b0, '0);
        idle(2);
        drive(1'b0, '0, 1'b1, 1'b0, '0);
        chk(cpu_hold, 1, "R4 read in period 3 holds");
        drive(1'b0, '0, 1'b1, 1'b0, '0);
        chk(cpu_hold, 1, "R4 read in period 4 holds");
        rd_expect(16'h1111, "R5 R7 first word");
        rd_expect(16'h2222, "R5 R7 partner word");
        rd_expect(16'h1111, "R6 saturated period");
        idle(3);
        rd_expect(16'h1111, "R6 long after");

        // R5 odd address: partner is address with bit 0 inverted
        read_pair(8'h11, 16'h2222, 16'h1111, "R5 odd address");

        // R8 single store in period 4 after a pair write
        write_pair(8'h20, 16'hAAAA, 16'hBBBB);
        drive(1'b1, 8'h20, 1'b0, 1'b0, '0);
        idle(3);
        drive(1'b0, '0, 1'b0, 1'b1, 16'h3333);
        idle(1);
        read_pair(8'h20, 16'h3333, 16'hBBBB, "R8 single store");
        chk(timing_err, 0, "R8 no error");

        // R13 ignored stores: no reference open, and period 6
        write_pair(8'h40, 16'h4444, 16'h5555);
        drive(1'b0, '0, 1'b0, 1'b1, 16'h7777);
        chk({cpu_hold, timing_err}, 2'b00, "R13 idle store");
        drive(1'b1, 8'h41, 1'b0, 1'b0, '0);
        idle(5);
        drive(1'b0, '0, 1'b0, 1'b1, 16'h7777);
        chk(cpu_hold, 0, "R13 period 6 store");
        idle(1);
        chk(timing_err, 0, "R13 no error");
        read_pair(8'h40, 16'h4444, 16'h5555, "R13 memory kept");

        // R11 address request while open
        drive(1'b1, 8'h10, 1'b0, 1'b0, '0);
        drive(1'b1, 8'h30, 1'b0, 1'b0, '0);
        chk(cpu_hold, 1, "R11 R4 hold");
        idle(1);
        chk(timing_err, 1, "R11 error set");
        idle(2);
        rd_expect(16'h1111, "R11 reference kept");
        chk(cpu_hold, 0, "R11 period count kept");
        rd_expect(16'h2222, "R11 partner kept");
        // R12 sticky
        idle(1);
        read_pair(8'h20, 16'h3333, 16'hBBBB, "R12 legal traffic");
        chk(timing_err, 1, "R12 still set");
        do_reset();
        chk(timing_err, 0, "R12 cleared by reset");

        // R9 early read
        drive(1'b1, 8'h10, 1'b0, 1'b0, '0);
        drive(1'b0, '0, 1'b1, 1'b0, '0);
        idle(1);
        chk(timing_err, 1, "R9 read in period 1");
        do_reset();
        drive(1'b1, 8'h10, 1'b0, 1'b0, '0);
        idle(1);
        drive(1'b0, '0, 1'b1, 1'b0, '0);
        idle(1);
        chk(timing_err, 1, "R9 read in period 2");
        do_reset();

        // R10 illegal stores in periods 1, 2, 5
        for (int p = 1; p <= 5; p += 1) begin
            if (p == 3 || p == 4) continue;
            drive(1'b1, 8'h40, 1'b0, 1'b0, '0);
            idle(p - 1);
            drive(1'b0, '0, 1'b0, 1'b1, 16'h9999);
            idle(1);
            chk(timing_err, 1, $sformatf("R10 store in period %0d", p));
            do_reset();
        end
        read_pair(8'h40, 16'h4444, 16'h5555, "R10 memory kept");
        chk(timing_err, 0, "R10 clean read-back");

        idle(2);
        chk(exp_q.size(), 0, "R5 all reads seen");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule